// File: doc/BRIEF.md
# Memory and I/O Chip-Select Decoder

This block sits on the demultiplexed bus of a small processor that has an 8-bit data path and a 20-bit address (1 MB of memory space). Each clock it looks at the latched address, the space select (high means I/O, low means memory) and the two active-low strobes. From these it drives active-low selects for three targets:

- a 32 KB boot ROM at the top of memory, which holds the reset fetch address FFFF0H;
- a 512 KB static RAM at the bottom of memory, built from sixteen 32 KB banks;
- a four-register peripheral port block in the 16-bit I/O space.

All selects and the register index are registered, so they follow the bus inputs by one clock. The boot ROM is too slow to fit the normal access window. A small counter therefore pulls the READY output low for one clock at the start of each ROM read, which inserts one wait state. RAM and port accesses run without waits.

Top module: `bus_select_decoder`

## Requirements
- R1: While reset is high and on the first clock after it, every select (`rom_cs_n`, all bits of `ram_bank_cs_n`, `port_cs_n`) is 1, `ready` is 1 and `port_reg` is 0.
- R2: A memory read (`io_sel`=0, `rd_n`=0, `wr_n`=1) with address F8000H..FFFFFH drives `rom_cs_n` low on the clock after it is sampled. A memory write in that range leaves `rom_cs_n` high.
- R3: A memory read or write with address 00000H..7FFFFH drives exactly one bank select low on the next clock: bit `addr[18:15]` of `ram_bank_cs_n`, with all other bits high.
- R4: Memory addresses 80000H..F7FFFH assert no select.
- R5: An I/O read or write (`io_sel`=1) whose low 16 address bits lie in 0060H..0063H drives `port_cs_n` low on the next clock, with `port_reg` = `addr[1:0]`. Address bits 19..16 have no effect. When the port is not selected, `port_reg` is 0.
- R6: Memory selects never assert during I/O cycles, and `port_cs_n` never asserts during memory cycles.
- R7: When both strobes are high, or both are low, no select asserts.
- R8: `ready` is 0 for exactly the one clock after a ROM read is first sampled, meaning the previous sampled cycle was not a ROM read. It is 1 on every other clock, including while a ROM read is held.
- R9: At most one select output is low on any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Latched bus address; low 16 bits are the I/O port number |
| io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| ram_bank_cs_n | output | 16 | RAM bank selects, active low, bit n = bank n |
| port_cs_n | output | 1 | Peripheral port block select, active low |
| port_reg | output | 2 | Register index within the port block |
| ready | output | 1 | Low for one clock to insert a ROM wait state |

## Verification
The assertions assume that the address, space select and strobes are stable across each sampling edge. They also assume the bench samples the registered outputs one clock after the inputs that caused them. The stimulus meets this by changing every input only on the falling edge and holding each vector across exactly one rising edge. Random vectors are biased toward the ROM, RAM, gap and port windows and the edges of each window. They include idle and conflicting strobe patterns, and back-to-back ROM reads that exercise both the first-read wait and the no-wait case when a read is held.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // exactly one strobe low makes a cycle; both or neither is no cycle
  function automatic cyc_kind_e classify(input logic rd_n, input logic wr_n);
    if (!rd_n && wr_n)      return CYC_READ;
    else if (rd_n && !wr_n) return CYC_WRITE;
    else                    return CYC_NONE;
  endfunction
endpackage

// File: rtl/mem_region_match.sv
module mem_region_match
  import bsd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ROM_BITS  = 15,
  parameter int RAM_BITS  = 19,
  parameter int BANK_BITS = 15,
  localparam int HI_W     = ADDR_W - BANK_BITS,
  localparam int IDX_W    = RAM_BITS - BANK_BITS,
  localparam int NBANK    = 1 << IDX_W
) (
  input  logic [HI_W-1:0]  addr_hi,
  input  logic             mem_cyc,
  input  cyc_kind_e        kind,
  output logic             rom_hit,
  output logic [NBANK-1:0] bank_hit
);
  logic             in_rom;
  logic             in_ram;
  logic [IDX_W-1:0] idx;

  assign in_rom  = &addr_hi[HI_W-1:ROM_BITS-BANK_BITS];
  assign in_ram  = ~|addr_hi[HI_W-1:IDX_W];
  assign idx     = addr_hi[IDX_W-1:0];
  assign rom_hit = mem_cyc && in_rom && (kind == CYC_READ);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [IDX_W-1:0] BI = IDX_W'(b);
    assign bank_hit[b] = mem_cyc && in_ram && (kind != CYC_NONE) && (idx == BI);
  end
endmodule

// File: rtl/io_port_match.sv
module io_port_match
  import bsd_pkg::*;
#(
  parameter int          IO_W      = 16,
  parameter logic [15:0] PORT_BASE = 16'h0060,
  parameter int          PORT_REGS = 4,
  localparam int         REG_BITS  = $clog2(PORT_REGS)
) (
  input  logic [IO_W-1:0]     port_addr,
  input  logic                io_cyc,
  input  cyc_kind_e           kind,
  output logic                port_hit,
  output logic [REG_BITS-1:0] reg_idx
);
  localparam logic [IO_W-1:0] BASE = IO_W'(PORT_BASE);

  assign port_hit = io_cyc && (kind != CYC_NONE) &&
                    (port_addr[IO_W-1:REG_BITS] == BASE[IO_W-1:REG_BITS]);
  assign reg_idx  = port_hit ? port_addr[REG_BITS-1:0] : '0;
endmodule

// File: rtl/rom_wait_gen.sv
module rom_wait_gen #(
  parameter int  WAIT_STATES = 1,
  localparam int CNT_W       = $clog2(WAIT_STATES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rom_read,
  output logic ready_o
);
  logic             seen_q;
  logic             start;
  logic [CNT_W-1:0] cnt_q;

  assign start   = rom_read && !seen_q;
  assign ready_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= rom_read;
      if (start)              cnt_q <= CNT_W'(WAIT_STATES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(1) && !start) |=> ready_o);  // R8
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= CNT_W'(WAIT_STATES)));  // R8
endmodule

// File: rtl/bus_select_decoder.sv
module bus_select_decoder
  import bsd_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          IO_W        = 16,
  parameter int          ROM_BITS    = 15,
  parameter int          RAM_BITS    = 19,
  parameter int          BANK_BITS   = 15,
  parameter logic [15:0] PORT_BASE   = 16'h0060,
  parameter int          PORT_REGS   = 4,
  parameter int          WAIT_STATES = 1,
  localparam int         NBANK       = 1 << (RAM_BITS - BANK_BITS),
  localparam int         REG_BITS    = $clog2(PORT_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                io_sel,
  input  logic                rd_n,
  input  logic                wr_n,
  output logic                rom_cs_n,
  output logic [NBANK-1:0]    ram_bank_cs_n,
  output logic                port_cs_n,
  output logic [REG_BITS-1:0] port_reg,
  output logic                ready
);
  cyc_kind_e           kind;
  logic                rom_hit;
  logic [NBANK-1:0]    bank_hit;
  logic                port_hit;
  logic [REG_BITS-1:0] reg_idx;

  assign kind = classify(rd_n, wr_n);

  mem_region_match #(
    .ADDR_W(ADDR_W), .ROM_BITS(ROM_BITS), .RAM_BITS(RAM_BITS), .BANK_BITS(BANK_BITS)
  ) u_mem (
    .addr_hi (addr[ADDR_W-1:BANK_BITS]),
    .mem_cyc (!io_sel),
    .kind    (kind),
    .rom_hit (rom_hit),
    .bank_hit(bank_hit)
  );

  io_port_match #(
    .IO_W(IO_W), .PORT_BASE(PORT_BASE), .PORT_REGS(PORT_REGS)
  ) u_io (
    .port_addr(addr[IO_W-1:0]),
    .io_cyc   (io_sel),
    .kind     (kind),
    .port_hit (port_hit),
    .reg_idx  (reg_idx)
  );

  rom_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .rom_read(rom_hit),
    .ready_o (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n      <= 1'b1;
      ram_bank_cs_n <= '1;
      port_cs_n     <= 1'b1;
      port_reg      <= '0;
    end else begin
      rom_cs_n      <= !rom_hit;
      ram_bank_cs_n <= ~bank_hit;
      port_cs_n     <= !port_hit;
      port_reg      <= reg_idx;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $countones({~rom_cs_n, ~ram_bank_cs_n, ~port_cs_n}) <= 1);  // R9
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ram_bank_cs_n));  // R3
  AST_NO_STROBE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    (rd_n == wr_n) |=> (rom_cs_n && (&ram_bank_cs_n) && port_cs_n));  // R7
  AST_ROM_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!io_sel && rd_n && !wr_n) |=> rom_cs_n);  // R2
  AST_IO_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    io_sel |=> (rom_cs_n && (&ram_bank_cs_n)));  // R6
  AST_MEM_NO_PORT: assert property (@(posedge clk) disable iff (rst)
    !io_sel |=> port_cs_n);  // R6
  AST_WAIT_ONLY_ROM: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !rom_cs_n);  // R8
endmodule

// File: tb/bus_select_decoder_tb.sv
module bus_select_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] addr;
  logic        io_sel, rd_n, wr_n;
  logic        rom_cs_n, port_cs_n, ready;
  logic [15:0] ram_bank_cs_n;
  logic [1:0]  port_reg;

  int n_vec = 0;
  int n_bad = 0;
  logic prev_rom_rd = 1'b0;

  always #4 clk = ~clk;

  bus_select_decoder u_dut (
    .clk(clk), .rst(rst), .addr(addr), .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n),
    .rom_cs_n(rom_cs_n), .ram_bank_cs_n(ram_bank_cs_n), .port_cs_n(port_cs_n),
    .port_reg(port_reg), .ready(ready)
  );

  function automatic logic f_rom(input logic [19:0] a, input logic io, input logic r, input logic w);
    return !io && !r && w && (a >= 20'hF8000);
  endfunction

  function automatic logic [15:0] f_bank(input logic [19:0] a, input logic io, input logic r, input logic w);
    logic [15:0] v = 16'hFFFF;
    if (!io && (r != w) && a < 20'h80000) v[a[18:15]] = 1'b0;
    return v;
  endfunction

  function automatic logic f_port(input logic [19:0] a, input logic io, input logic r, input logic w);
    return io && (r != w) && (a[15:0] >= 16'h0060) && (a[15:0] <= 16'h0063);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (addr=%h io=%b rd_n=%b wr_n=%b)",
               req, act, exp, addr, io_sel, rd_n, wr_n);
    end
  endtask

  // hold one vector across one rising edge, then check at the falling edge
  task automatic apply(input logic [19:0] a, input logic io, input logic r, input logic w);
    logic rr, er, ep;
    @(negedge clk);
    addr = a; io_sel = io; rd_n = r; wr_n = w;
    @(negedge clk);
    rr = f_rom(a, io, r, w);
    ep = f_port(a, io, r, w);
    check("R2 rom_cs_n", {31'd0, rom_cs_n}, {31'd0, !rr});
    check("R3 ram_bank_cs_n", {16'd0, ram_bank_cs_n}, {16'd0, f_bank(a, io, r, w)});
    check("R5 port_cs_n", {31'd0, port_cs_n}, {31'd0, !ep});
    check("R5 port_reg", {30'd0, port_reg}, {30'd0, ep ? a[1:0] : 2'b00});
    er = !(rr && !prev_rom_rd);
    check("R8 ready", {31'd0, ready}, {31'd0, er});
    prev_rom_rd = rr;
  endtask

  function automatic logic [19:0] pick_addr(input int cat);
    case (cat)
      0: return 20'hF8000 | 20'($urandom_range(0, 20'h7FFF));
      1: return 20'($urandom_range(0, 20'h7FFFF));
      2: return 20'h80000 + 20'($urandom_range(0, 20'h77FFF));
      3: return {4'($urandom), 16'h005C + 16'($urandom_range(0, 11))};
      default: return 20'($urandom);
    endcase
  endfunction

  initial begin
    logic [19:0] a;
    logic        io;
    int          s;
    void'($urandom(32'h5eed_1234));
    addr = '0; io_sel = 0; rd_n = 1; wr_n = 1; rst = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rom_cs_n", {31'd0, rom_cs_n}, 32'd1);
    check("R1 ram_bank_cs_n", {16'd0, ram_bank_cs_n}, 32'h0000FFFF);
    check("R1 port_cs_n", {31'd0, port_cs_n}, 32'd1);
    check("R1 port_reg", {30'd0, port_reg}, 32'd0);
    check("R1 ready", {31'd0, ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after release", {31'd0, ready}, 32'd1);

    // directed corners
    apply(20'hFFFF0, 0, 0, 1);   // R2 reset fetch, R8 wait
    apply(20'hFFFF1, 0, 0, 1);   // R8 held ROM read: no wait
    apply(20'hF8000, 0, 1, 0);   // R2 ROM write blocked
    apply(20'hF8000, 0, 0, 1);   // R2 low edge, R8 new wait
    apply(20'hF7FFF, 0, 0, 1);   // R4 gap top
    apply(20'h80000, 0, 1, 0);   // R4 gap bottom
    apply(20'h7FFFF, 0, 1, 0);   // R3 bank 15
    apply(20'h00000, 0, 0, 1);   // R3 bank 0
    apply(20'h00000, 0, 0, 0);   // R7 both strobes
    apply(20'hFFFF0, 0, 1, 1);   // R7 no strobe
    apply(20'hA0060, 1, 0, 1);   // R5 upper bits ignored
    apply(20'h00063, 1, 1, 0);   // R5 last register
    apply(20'h00064, 1, 0, 1);   // R5 just above
    apply(20'h0005F, 1, 0, 1);   // R5 just below
    apply(20'h00060, 0, 0, 1);   // R6 port addr in memory space -> RAM bank 0
    apply(20'hFFFF0, 1, 0, 1);   // R6 ROM addr in I/O space
    apply(20'h00061, 1, 0, 0);   // R7 conflict in I/O

    // random vectors; R9 is covered since each check compares every output
    for (int i = 0; i < 3000; i++) begin
      a  = pick_addr($urandom_range(0, 4));
      io = ($urandom_range(0, 3) == 0) ? ~a[19] : a[19] ^ a[0];
      s  = $urandom_range(0, 9);
      if (s < 4)      apply(a, io, 0, 1);
      else if (s < 8) apply(a, io, 1, 0);
      else if (s == 8) apply(a, io, 1, 1);
      else            apply(a, io, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule